// File: doc/BRIEF.md
# USB Endpoint Packet DMA Engine

This block is one DMA channel that moves USB packet data between system memory and an endpoint FIFO. A byte-wide master port on a pipelined system bus reaches memory. All data passes through a small staging buffer, so the channel works in two alternating phases. In the bus phase it holds a bus request and makes memory beats. In the FIFO phase the bus is released and only the FIFO strobes move. The two phases never overlap.

In the load direction (memory to FIFO), the channel reads memory into the buffer until the packet has been read or the buffer is full. It then drains the buffer into the FIFO and repeats until the packet is complete. In the unload direction (FIFO to memory), it fills the buffer from the FIFO first. Only then does it request the bus and write the buffer to consecutive addresses.

Single-packet mode moves one packet per start, for any endpoint type. Bulk mode moves a whole multi-packet transfer and reports completion once at the end. In bulk unload, a short packet ends the transfer early. A bus error stops the channel at once. While a register slave access is in progress, FIFO activity pauses.

Top module: `usb_pkt_dma`

## Requirements
- R1: After reset, ch_enable, bus_req, mem_valid, fifo_wr_en, fifo_rd_en, irq_done, irq_err and stat_bus_err are all 0.
- R2: A cfg_start pulse while ch_enable is 0 latches cfg_addr, cfg_count, cfg_mode and cfg_dir. With a nonzero count, ch_enable is 1 from the next cycle. With a zero count, irq_done pulses in the next cycle and no data moves. A cfg_start pulse while ch_enable is 1 has no effect on the running transfer.
- R3: Load (cfg_dir=0) reads memory at cfg_addr, cfg_addr+1, and so on. Each bus phase holds at most BUF_BYTES bytes and ends at a packet boundary. The bytes reach the FIFO in address order. fifo_wlast marks the last byte of every packet, where packets are MAX_PKT bytes long except the final remainder.
- R4: Unload (cfg_dir=1) reads FIFO bytes into the buffer until the packet ends or BUF_BYTES bytes are held, and only then raises bus_req. It writes the bytes in order to consecutive addresses starting at cfg_addr, one bus phase per buffer fill, and writes no memory beyond the last byte moved.
- R5: bus_req is never 1 in a cycle in which fifo_wr_en or fifo_rd_en is 1.
- R6: Single-packet mode (cfg_mode=0) moves min(cfg_count, MAX_PKT) bytes, then completes.
- R7: Bulk mode (cfg_mode=1) moves all cfg_count bytes as a series of packets and raises exactly one irq_done, at the end.
- R8: In bulk unload, a packet whose fifo_rlast arrives before its length reaches min(remaining count, MAX_PKT) is a short packet. The transfer completes after that packet is written to memory.
- R9: When mem_valid and mem_err are both 1, the transfer ends. In the next cycle irq_err pulses, stat_bus_err is 1 and ch_enable is 0. No further strobes follow. stat_bus_err stays set until the next accepted cfg_start clears it.
- R10: While reg_access is 1, fifo_wr_en and fifo_rd_en stay 0. The transfer resumes when reg_access drops.
- R11: mem_valid is 1 only while bus_req and bus_gnt are both 1. If the grant is withdrawn, bus_req stays high, mem_addr holds, and buffered data is kept.
- R12: fifo_wr_en is never 1 while fifo_full is 1, and fifo_rd_en is never 1 while fifo_empty is 1.
- R13: irq_done is a one-cycle pulse. It appears in the same cycle that ch_enable returns to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_start | input | 1 | Start pulse; accepted while idle |
| cfg_addr | input | AW | Memory start address |
| cfg_count | input | CW | Byte count of the transfer |
| cfg_mode | input | 1 | 0 single packet, 1 bulk transfer |
| cfg_dir | input | 1 | 0 load (memory to FIFO), 1 unload (FIFO to memory) |
| reg_access | input | 1 | Register slave access in progress; pauses FIFO activity |
| bus_req | output | 1 | Bus ownership request |
| bus_gnt | input | 1 | Bus ownership grant |
| mem_valid | output | 1 | Memory beat issued this cycle |
| mem_write | output | 1 | Beat is a write |
| mem_addr | output | AW | Beat byte address |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid with mem_ready |
| mem_ready | input | 1 | Beat completes this cycle |
| mem_err | input | 1 | Beat ends in a bus error |
| fifo_wr_en | output | 1 | FIFO push strobe |
| fifo_wdata | output | 8 | FIFO push data |
| fifo_wlast | output | 1 | Pushed byte ends a packet |
| fifo_full | input | 1 | FIFO cannot accept a byte |
| fifo_rd_en | output | 1 | FIFO pop strobe |
| fifo_rdata | input | 8 | Head byte of the FIFO |
| fifo_rlast | input | 1 | Head byte ends a packet |
| fifo_empty | input | 1 | FIFO has no byte |
| ch_enable | output | 1 | Channel busy; cleared on completion or error |
| irq_done | output | 1 | Completion interrupt pulse |
| irq_err | output | 1 | Bus-error interrupt pulse |
| stat_bus_err | output | 1 | Sticky bus-error status |

## Verification
The bench builds the channel with BUF_BYTES=4, MAX_PKT=6, AW=8 and CW=6. With these values a packet needs two buffer fills, one of them partial. Every count from 0 to 13 therefore covers empty transfers, sub-buffer packets, full packets and trailing remainders in both directions and both modes. The small bus and count widths keep a complete memory image in the bench. Grant withdrawal, FIFO back-pressure and register-access pauses are laid over each run in patterns derived from the count. Short-packet, error and busy-start cases are added by hand.

// File: rtl/usb_pkt_dma_pkg.sv
package usb_pkt_dma_pkg;
   typedef enum logic [2:0] {
      ST_IDLE    = 3'd0,
      ST_MEM_RD  = 3'd1,
      ST_FIFO_WR = 3'd2,
      ST_FIFO_RD = 3'd3,
      ST_MEM_WR  = 3'd4
   } dma_state_e;

   typedef enum logic {
      DIR_LOAD   = 1'b0,
      DIR_UNLOAD = 1'b1
   } dma_dir_e;

   typedef enum logic {
      MODE_SINGLE = 1'b0,
      MODE_BULK   = 1'b1
   } dma_mode_e;
endpackage

// File: rtl/usb_pkt_dma_buf.sv
module usb_pkt_dma_buf #(
   parameter int DEPTH = 64,
   parameter int DW    = 8,
   localparam int IW   = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          wr_en,
   input  logic [IW-1:0] wr_idx,
   input  logic [DW-1:0] wr_data,
   input  logic [IW-1:0] rd_idx,
   output logic [DW-1:0] rd_data
);
   if (DEPTH < 2 || (1 << IW) != DEPTH) begin : g_bad_depth
      $error("usb_pkt_dma_buf: DEPTH must be a power of two of at least 2");
   end

   logic [DW-1:0] ent [DEPTH];

   for (genvar i = 0; i < DEPTH; i++) begin : g_ent
      logic [DW-1:0] ent_q;
      always_ff @(posedge clk) begin
         if (wr_en && wr_idx == IW'(i)) ent_q <= wr_data;
      end
      assign ent[i] = ent_q;
   end

   assign rd_data = ent[rd_idx];
endmodule

// File: rtl/usb_pkt_dma_fsm.sv
module usb_pkt_dma_fsm
   import usb_pkt_dma_pkg::*;
#(
   parameter int AW        = 32,
   parameter int CW        = 16,
   parameter int BUF_BYTES = 64,
   parameter int MAX_PKT   = 64,
   localparam int IW       = $clog2(BUF_BYTES)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [AW-1:0] start_addr,
   input  logic [CW-1:0] start_count,
   input  logic          start_mode,
   input  logic          start_dir,
   input  logic          reg_access,
   output logic          bus_req,
   input  logic          bus_gnt,
   output logic          mem_valid,
   output logic          mem_write,
   output logic [AW-1:0] mem_addr,
   input  logic          mem_ready,
   input  logic          mem_err,
   output logic          fifo_wr_en,
   output logic          fifo_wlast,
   input  logic          fifo_full,
   output logic          fifo_rd_en,
   input  logic          fifo_rlast,
   input  logic          fifo_empty,
   output logic          buf_wr_en,
   output logic [IW-1:0] buf_wr_idx,
   output logic [IW-1:0] buf_rd_idx,
   output logic          buf_from_fifo,
   output logic          ch_enable,
   output logic          irq_done,
   output logic          irq_err,
   output logic          stat_bus_err
);
   localparam int FW = IW + 1;
   localparam logic [FW-1:0] FILL_TOP = FW'(BUF_BYTES - 1);
   localparam logic [CW-1:0] PKT_CAP  = CW'(MAX_PKT);

   if (MAX_PKT < 1 || MAX_PKT >= (1 << CW)) begin : g_bad_pkt
      $error("usb_pkt_dma_fsm: MAX_PKT must be at least 1 and fit in CW bits");
   end

   function automatic logic [CW-1:0] clamp_pkt(input logic [CW-1:0] n);
      return (n > PKT_CAP) ? PKT_CAP : n;
   endfunction

   dma_state_e    state_q;
   dma_dir_e      dir_q;
   dma_mode_e     mode_q;
   logic [AW-1:0] addr_q;
   logic [CW-1:0] rem_q, pkt_left_q;
   logic [FW-1:0] fill_q, drain_q;
   logic          pkt_end_q, short_q;

   logic mem_ok, mem_bad, last_in_buf, buf_full_now, rd_pkt_end, stop_after;

   assign bus_req      = (state_q == ST_MEM_RD) || (state_q == ST_MEM_WR);
   assign mem_valid    = bus_req && bus_gnt;
   assign mem_write    = (state_q == ST_MEM_WR);
   assign mem_addr     = addr_q;
   assign mem_ok       = mem_valid && mem_ready && !mem_err;
   assign mem_bad      = mem_valid && mem_err;
   assign fifo_wr_en   = (state_q == ST_FIFO_WR) && !fifo_full && !reg_access;
   assign fifo_rd_en   = (state_q == ST_FIFO_RD) && !fifo_empty && !reg_access;
   assign last_in_buf  = (drain_q + FW'(1)) == fill_q;
   assign buf_full_now = (fill_q == FILL_TOP);
   assign fifo_wlast   = fifo_wr_en && last_in_buf && pkt_end_q;
   assign rd_pkt_end   = fifo_rlast || (pkt_left_q == CW'(1));
   assign stop_after   = (mode_q == MODE_SINGLE) || (rem_q == '0) || short_q;
   assign buf_wr_en    = ((state_q == ST_MEM_RD) && mem_ok) || fifo_rd_en;
   assign buf_wr_idx   = fill_q[IW-1:0];
   assign buf_rd_idx   = drain_q[IW-1:0];
   assign buf_from_fifo = (dir_q == DIR_UNLOAD);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q      <= ST_IDLE;
         dir_q        <= DIR_LOAD;
         mode_q       <= MODE_SINGLE;
         addr_q       <= '0;
         rem_q        <= '0;
         pkt_left_q   <= '0;
         fill_q       <= '0;
         drain_q      <= '0;
         pkt_end_q    <= 1'b0;
         short_q      <= 1'b0;
         ch_enable    <= 1'b0;
         irq_done     <= 1'b0;
         irq_err      <= 1'b0;
         stat_bus_err <= 1'b0;
      end else begin
         irq_done <= 1'b0;
         irq_err  <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (start) begin
                  dir_q        <= dma_dir_e'(start_dir);
                  mode_q       <= dma_mode_e'(start_mode);
                  addr_q       <= start_addr;
                  rem_q        <= start_count;
                  pkt_left_q   <= clamp_pkt(start_count);
                  fill_q       <= '0;
                  drain_q      <= '0;
                  pkt_end_q    <= 1'b0;
                  short_q      <= 1'b0;
                  stat_bus_err <= 1'b0;
                  if (start_count == '0) begin
                     irq_done <= 1'b1;
                  end else begin
                     ch_enable <= 1'b1;
                     state_q   <= start_dir ? ST_FIFO_RD : ST_MEM_RD;
                  end
               end
            end
            ST_MEM_RD: begin
               if (mem_bad) begin
                  state_q      <= ST_IDLE;
                  ch_enable    <= 1'b0;
                  irq_err      <= 1'b1;
                  stat_bus_err <= 1'b1;
               end else if (mem_ok) begin
                  addr_q     <= addr_q + AW'(1);
                  rem_q      <= rem_q - CW'(1);
                  pkt_left_q <= pkt_left_q - CW'(1);
                  fill_q     <= fill_q + FW'(1);
                  if (pkt_left_q == CW'(1) || buf_full_now) begin
                     state_q   <= ST_FIFO_WR;
                     drain_q   <= '0;
                     pkt_end_q <= (pkt_left_q == CW'(1));
                  end
               end
            end
            ST_FIFO_WR: begin
               if (fifo_wr_en) begin
                  drain_q <= drain_q + FW'(1);
                  if (last_in_buf) begin
                     fill_q  <= '0;
                     drain_q <= '0;
                     if (!pkt_end_q) begin
                        state_q <= ST_MEM_RD;
                     end else if (stop_after) begin
                        state_q   <= ST_IDLE;
                        ch_enable <= 1'b0;
                        irq_done  <= 1'b1;
                     end else begin
                        pkt_left_q <= clamp_pkt(rem_q);
                        pkt_end_q  <= 1'b0;
                        state_q    <= ST_MEM_RD;
                     end
                  end
               end
            end
            ST_FIFO_RD: begin
               if (fifo_rd_en) begin
                  rem_q      <= rem_q - CW'(1);
                  pkt_left_q <= pkt_left_q - CW'(1);
                  fill_q     <= fill_q + FW'(1);
                  if (rd_pkt_end || buf_full_now) begin
                     state_q   <= ST_MEM_WR;
                     drain_q   <= '0;
                     pkt_end_q <= rd_pkt_end;
                     short_q   <= fifo_rlast && (pkt_left_q != CW'(1));
                  end
               end
            end
            ST_MEM_WR: begin
               if (mem_bad) begin
                  state_q      <= ST_IDLE;
                  ch_enable    <= 1'b0;
                  irq_err      <= 1'b1;
                  stat_bus_err <= 1'b1;
               end else if (mem_ok) begin
                  addr_q  <= addr_q + AW'(1);
                  drain_q <= drain_q + FW'(1);
                  if (last_in_buf) begin
                     fill_q  <= '0;
                     drain_q <= '0;
                     if (!pkt_end_q) begin
                        state_q <= ST_FIFO_RD;
                     end else if (stop_after) begin
                        state_q   <= ST_IDLE;
                        ch_enable <= 1'b0;
                        irq_done  <= 1'b1;
                     end else begin
                        pkt_left_q <= clamp_pkt(rem_q);
                        pkt_end_q  <= 1'b0;
                        state_q    <= ST_FIFO_RD;
                     end
                  end
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/usb_pkt_dma.sv
module usb_pkt_dma #(
   parameter int AW        = 32,
   parameter int CW        = 16,
   parameter int BUF_BYTES = 64,
   parameter int MAX_PKT   = 64
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cfg_start,
   input  logic [AW-1:0] cfg_addr,
   input  logic [CW-1:0] cfg_count,
   input  logic          cfg_mode,
   input  logic          cfg_dir,
   input  logic          reg_access,
   output logic          bus_req,
   input  logic          bus_gnt,
   output logic          mem_valid,
   output logic          mem_write,
   output logic [AW-1:0] mem_addr,
   output logic [7:0]    mem_wdata,
   input  logic [7:0]    mem_rdata,
   input  logic          mem_ready,
   input  logic          mem_err,
   output logic          fifo_wr_en,
   output logic [7:0]    fifo_wdata,
   output logic          fifo_wlast,
   input  logic          fifo_full,
   output logic          fifo_rd_en,
   input  logic [7:0]    fifo_rdata,
   input  logic          fifo_rlast,
   input  logic          fifo_empty,
   output logic          ch_enable,
   output logic          irq_done,
   output logic          irq_err,
   output logic          stat_bus_err
);
   localparam int IW = $clog2(BUF_BYTES);

   logic          buf_wr_en, buf_from_fifo;
   logic [IW-1:0] buf_wr_idx, buf_rd_idx;
   logic [7:0]    buf_wdata, buf_rdata;

   assign buf_wdata  = buf_from_fifo ? fifo_rdata : mem_rdata;
   assign mem_wdata  = buf_rdata;
   assign fifo_wdata = buf_rdata;

   usb_pkt_dma_fsm #(
      .AW(AW), .CW(CW), .BUF_BYTES(BUF_BYTES), .MAX_PKT(MAX_PKT)
   ) u_fsm (
      .clk(clk), .rst_n(rst_n),
      .start(cfg_start), .start_addr(cfg_addr), .start_count(cfg_count),
      .start_mode(cfg_mode), .start_dir(cfg_dir), .reg_access(reg_access),
      .bus_req(bus_req), .bus_gnt(bus_gnt), .mem_valid(mem_valid),
      .mem_write(mem_write), .mem_addr(mem_addr), .mem_ready(mem_ready),
      .mem_err(mem_err), .fifo_wr_en(fifo_wr_en), .fifo_wlast(fifo_wlast),
      .fifo_full(fifo_full), .fifo_rd_en(fifo_rd_en), .fifo_rlast(fifo_rlast),
      .fifo_empty(fifo_empty), .buf_wr_en(buf_wr_en), .buf_wr_idx(buf_wr_idx),
      .buf_rd_idx(buf_rd_idx), .buf_from_fifo(buf_from_fifo),
      .ch_enable(ch_enable), .irq_done(irq_done), .irq_err(irq_err),
      .stat_bus_err(stat_bus_err)
   );

   usb_pkt_dma_buf #(.DEPTH(BUF_BYTES), .DW(8)) u_buf (
      .clk(clk), .wr_en(buf_wr_en), .wr_idx(buf_wr_idx), .wr_data(buf_wdata),
      .rd_idx(buf_rd_idx), .rd_data(buf_rdata)
   );
endmodule

// File: rtl/usb_pkt_dma_chk.sv
module usb_pkt_dma_chk #(
   parameter int AW = 32
) (
   input logic          clk,
   input logic          rst_n,
   input logic          reg_access,
   input logic          bus_req,
   input logic          bus_gnt,
   input logic          mem_valid,
   input logic [AW-1:0] mem_addr,
   input logic          mem_ready,
   input logic          mem_err,
   input logic          fifo_wr_en,
   input logic          fifo_full,
   input logic          fifo_rd_en,
   input logic          fifo_empty,
   input logic          ch_enable,
   input logic          irq_done,
   input logic          irq_err,
   input logic          stat_bus_err
);
   // R5
   phase_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_req && (fifo_wr_en || fifo_rd_en)));
   // R10
   slave_pause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      reg_access |-> !(fifo_wr_en || fifo_rd_en));
   // R12
   push_flow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_wr_en |-> !fifo_full);
   // R12
   pop_flow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_rd_en |-> !fifo_empty);
   // R11
   grant_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_valid |-> (bus_req && bus_gnt));
   // R11
   addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && !mem_valid) |=> $stable(mem_addr));
   // R3
   addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_valid && mem_ready && !mem_err) |=> (mem_addr == $past(mem_addr) + AW'(1)));
   // R9
   bus_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_valid && mem_err) |=> (irq_err && stat_bus_err && !ch_enable));
   // R13
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_done |=> !irq_done);
   // R13
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_done |-> !ch_enable);
endmodule

bind usb_pkt_dma usb_pkt_dma_chk #(.AW(AW)) u_chk (
   .clk(clk), .rst_n(rst_n), .reg_access(reg_access), .bus_req(bus_req),
   .bus_gnt(bus_gnt), .mem_valid(mem_valid), .mem_addr(mem_addr),
   .mem_ready(mem_ready), .mem_err(mem_err), .fifo_wr_en(fifo_wr_en),
   .fifo_full(fifo_full), .fifo_rd_en(fifo_rd_en), .fifo_empty(fifo_empty),
   .ch_enable(ch_enable), .irq_done(irq_done), .irq_err(irq_err),
   .stat_bus_err(stat_bus_err)
);

// File: tb/usb_pkt_dma_tb_top.sv
module usb_pkt_dma_tb_top;
   localparam int AW = 8, CW = 6, BUFB = 4, PKT = 6;

   logic clk = 1'b0, rst_n = 1'b0;
   always #2 clk = ~clk;

   logic          cfg_start = 1'b0, cfg_mode = 1'b0, cfg_dir = 1'b0;
   logic [AW-1:0] cfg_addr = '0;
   logic [CW-1:0] cfg_count = '0;
   logic          reg_access, bus_req, bus_gnt, mem_valid, mem_write;
   logic [AW-1:0] mem_addr;
   logic [7:0]    mem_wdata, mem_rdata, fifo_wdata, fifo_rdata;
   logic          mem_ready, mem_err, fifo_wr_en, fifo_wlast, fifo_full;
   logic          fifo_rd_en, fifo_rlast, fifo_empty;
   logic          ch_enable, irq_done, irq_err, stat_bus_err;

   logic       clr = 1'b0, err_on = 1'b0;
   logic [AW-1:0] err_addr = '0;
   logic [2:0] patt = '0;
   int unsigned cyc = 0;
   logic [7:0] mem [256];
   logic [7:0] got [64];
   logic       gl [64];
   logic [7:0] src_d [64];
   logic       src_l [64];
   int         src_len = 0;
   logic [6:0] src_ptr;
   int gn, rises, done_cnt, err_cnt, v_ovl, v_ra, v_flow, v_gnt;
   logic req_d;
   int n_chk = 0, n_err = 0;
   bit finished = 1'b0;

   function automatic logic [7:0] memv(input int a);
      return 8'((a % 256) * 7 + 3);
   endfunction

   assign bus_gnt    = bus_req && !(patt[0] && (cyc % 3 == 2));
   assign fifo_full  = patt[1] && (cyc % 4 == 1);
   assign reg_access = patt[2] && (cyc % 5 == 3);
   assign mem_rdata  = mem[mem_addr];
   assign mem_ready  = 1'b1;
   assign mem_err    = err_on && mem_valid && (mem_addr == err_addr);
   assign fifo_empty = (int'(src_ptr) >= src_len) || (patt[1] && (cyc % 4 == 2));
   assign fifo_rdata = src_d[src_ptr[5:0]];
   assign fifo_rlast = src_l[src_ptr[5:0]];

   usb_pkt_dma #(.AW(AW), .CW(CW), .BUF_BYTES(BUFB), .MAX_PKT(PKT)) dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_start(cfg_start), .cfg_addr(cfg_addr),
      .cfg_count(cfg_count), .cfg_mode(cfg_mode), .cfg_dir(cfg_dir),
      .reg_access(reg_access), .bus_req(bus_req), .bus_gnt(bus_gnt),
      .mem_valid(mem_valid), .mem_write(mem_write), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready),
      .mem_err(mem_err), .fifo_wr_en(fifo_wr_en), .fifo_wdata(fifo_wdata),
      .fifo_wlast(fifo_wlast), .fifo_full(fifo_full), .fifo_rd_en(fifo_rd_en),
      .fifo_rdata(fifo_rdata), .fifo_rlast(fifo_rlast), .fifo_empty(fifo_empty),
      .ch_enable(ch_enable), .irq_done(irq_done), .irq_err(irq_err),
      .stat_bus_err(stat_bus_err)
   );

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (clr) begin
         for (int i = 0; i < 256; i++) mem[i] <= memv(i);
         gn <= 0; rises <= 0; done_cnt <= 0; err_cnt <= 0; req_d <= 1'b0;
         v_ovl <= 0; v_ra <= 0; v_flow <= 0; v_gnt <= 0; src_ptr <= '0;
      end else begin
         if (fifo_wr_en) begin got[gn] <= fifo_wdata; gl[gn] <= fifo_wlast; gn <= gn + 1; end
         if (fifo_rd_en) src_ptr <= src_ptr + 7'd1;
         if (mem_valid && mem_ready && !mem_err && mem_write) mem[mem_addr] <= mem_wdata;
         if (bus_req && !req_d) rises <= rises + 1;
         req_d <= bus_req;
         if (irq_done) done_cnt <= done_cnt + 1;
         if (irq_err) err_cnt <= err_cnt + 1;
         if (bus_req && (fifo_wr_en || fifo_rd_en)) v_ovl <= v_ovl + 1;
         if (reg_access && (fifo_wr_en || fifo_rd_en)) v_ra <= v_ra + 1;
         if ((fifo_wr_en && fifo_full) || (fifo_rd_en && fifo_empty)) v_flow <= v_flow + 1;
         if (mem_valid && !bus_gnt) v_gnt <= v_gnt + 1;
      end
   end

   task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic set_fifo(input int p0, input int p1, input int p2);
      int lens[3];
      int k;
      lens[0] = p0; lens[1] = p1; lens[2] = p2;
      k = 0;
      for (int i = 0; i < 3; i++)
         for (int j = 0; j < lens[i]; j++) begin
            src_d[k] = 8'(k * 5 + 17); src_l[k] = (j == lens[i] - 1); k++;
         end
      src_len = k;
   endtask

   task automatic begin_run(input bit dir, input bit mode, input int addr, input int cnt, input logic [2:0] p);
      @(negedge clk); clr = 1'b1; patt = '0;
      @(negedge clk); clr = 1'b0; patt = p;
      cfg_dir = dir; cfg_mode = mode; cfg_addr = AW'(addr); cfg_count = CW'(cnt); cfg_start = 1'b1;
      @(negedge clk); cfg_start = 1'b0;
      if (cnt == 0) chk(irq_done && !ch_enable, "R2", "zero count completes at once", int'(irq_done), 1);
      else chk(ch_enable, "R2", "enable after start", int'(ch_enable), 1);
      chk(!stat_bus_err, "R9", "status cleared by start", int'(stat_bus_err), 0);
   endtask

   task automatic finish_run();
      int t = 0;
      while (!(irq_done || irq_err) && t < 3000) begin @(negedge clk); t++; end
      chk(t < 3000, "R7", "run reached an end", t, 0);
      repeat (4) @(negedge clk);
      chk(v_ovl == 0, "R5", "bus and FIFO phases overlapped", v_ovl, 0);
      chk(v_ra == 0, "R10", "FIFO strobe during slave access", v_ra, 0);
      chk(v_flow == 0, "R12", "strobe against full/empty", v_flow, 0);
      chk(v_gnt == 0, "R11", "beat without grant", v_gnt, 0);
   endtask

   task automatic check_load(input bit mode, input int addr, input int cnt);
      int n = 0, ch = 0, rem = cnt, bad = 0;
      while (rem > 0) begin
         int lim = rem > PKT ? PKT : rem;
         n += lim; ch += (lim + BUFB - 1) / BUFB; rem -= lim;
         if (!mode) break;
      end
      chk(gn == n, mode ? "R7" : "R6", "bytes pushed to FIFO", gn, n);
      for (int k = 0; k < n && k < gn; k++) begin
         if (got[k] != memv(addr + k)) bad++;
         if (gl[k] != (((k + 1) % PKT == 0) || (k == n - 1))) bad++;
      end
      chk(bad == 0, "R3", "FIFO data and packet marks", bad, 0);
      chk(rises == ch, "R3", "bus phases per transfer", rises, ch);
      chk(done_cnt == 1 && err_cnt == 0, "R13", "single completion pulse", done_cnt, 1);
      chk(!ch_enable, "R13", "enable cleared at end", int'(ch_enable), 0);
   endtask

   task automatic check_unload(input bit mode, input int addr, input int cnt,
                               input int p0, input int p1, input int p2, input string req);
      int lens[3];
      int n = 0, ch = 0, rem = cnt, bad = 0;
      lens[0] = p0; lens[1] = p1; lens[2] = p2;
      for (int i = 0; i < 3; i++) begin
         int lim = rem > PKT ? PKT : rem;
         int take;
         if (lim == 0) break;
         take = lens[i] < lim ? lens[i] : lim;
         n += take; ch += (take + BUFB - 1) / BUFB; rem -= take;
         if (!mode || take < lim) break;
      end
      chk(int'(src_ptr) == n, req, "bytes popped from FIFO", int'(src_ptr), n);
      for (int k = 0; k < n; k++) if (mem[(addr + k) % 256] != src_d[k]) bad++;
      chk(bad == 0, "R4", "memory image of moved bytes", bad, 0);
      chk(mem[(addr + n) % 256] == memv(addr + n), "R4", "no write past end", int'(mem[(addr + n) % 256]), int'(memv(addr + n)));
      chk(rises == ch, "R4", "bus phases after buffer fills", rises, ch);
      chk(done_cnt == 1 && !ch_enable, "R13", "single completion pulse", done_cnt, 1);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      if (!finished) begin
         n_chk++; n_err++;
         $display("FAIL R7 watchdog expired: actual=1 expected=0");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      set_fifo(6, 6, 6);
      repeat (3) @(negedge clk);
      chk(!ch_enable && !bus_req && !mem_valid && !fifo_wr_en && !fifo_rd_en &&
          !irq_done && !irq_err && !stat_bus_err, "R1", "outputs in reset", int'(ch_enable), 0);
      rst_n = 1'b1;

      for (int m = 0; m < 2; m++)
         for (int c = 0; c < 14; c++) begin
            begin_run(1'b0, m[0], 16 + c * 3 + m, c, 3'(c));
            finish_run();
            check_load(m[0], 16 + c * 3 + m, c);
         end

      for (int m = 0; m < 2; m++)
         for (int c = 0; c < 14; c++) begin
            set_fifo(6, 6, 6);
            begin_run(1'b1, m[0], 120 + c * 4, c, 3'(c + 3));
            finish_run();
            check_unload(m[0], 120 + c * 4, c, 6, 6, 6, m[0] ? "R7" : "R6");
         end

      // R8 short packets in bulk and single mode
      set_fifo(6, 3, 0); begin_run(1'b1, 1'b1, 30, 20, 3'd7); finish_run(); check_unload(1'b1, 30, 20, 6, 3, 0, "R8");
      set_fifo(2, 6, 0); begin_run(1'b1, 1'b1, 60, 10, 3'd1); finish_run(); check_unload(1'b1, 60, 10, 2, 6, 0, "R8");
      set_fifo(6, 6, 1); begin_run(1'b1, 1'b1, 90, 30, 3'd6); finish_run(); check_unload(1'b1, 90, 30, 6, 6, 1, "R8");
      set_fifo(6, 6, 0); begin_run(1'b1, 1'b1, 200, 12, 3'd2); finish_run(); check_unload(1'b1, 200, 12, 6, 6, 0, "R8");
      set_fifo(3, 6, 0); begin_run(1'b1, 1'b0, 220, 5, 3'd0); finish_run(); check_unload(1'b0, 220, 5, 3, 6, 0, "R6");

      // R2 start while busy is ignored
      begin_run(1'b0, 1'b1, 40, 13, 3'd7);
      repeat (10) @(negedge clk);
      cfg_addr = 8'd100; cfg_count = 6'd3; cfg_mode = 1'b0; cfg_start = 1'b1;
      @(negedge clk); cfg_start = 1'b0;
      finish_run();
      check_load(1'b1, 40, 13);
      chk(gn == 13, "R2", "busy start left transfer intact", gn, 13);

      // R9 bus error on load
      err_on = 1'b1; err_addr = 8'd55;
      begin_run(1'b0, 1'b1, 50, 12, 3'd1);
      finish_run();
      chk(err_cnt == 1 && done_cnt == 0, "R9", "error pulse only", err_cnt, 1);
      chk(stat_bus_err && !ch_enable, "R9", "status set, channel off", int'(stat_bus_err), 1);
      chk(gn == 4, "R9", "bytes pushed before error", gn, 4);

      // R9 bus error on unload
      set_fifo(6, 6, 0); err_addr = 8'd72;
      begin_run(1'b1, 1'b1, 70, 12, 3'd0);
      finish_run();
      chk(err_cnt == 1 && stat_bus_err && !ch_enable, "R9", "unload error reported", err_cnt, 1);
      chk(mem[70] == src_d[0] && mem[71] == src_d[1] && mem[72] == memv(72), "R9", "writes stop at faulting beat", int'(mem[72]), int'(memv(72)));
      err_on = 1'b0;

      // R9 next accepted start clears the status
      begin_run(1'b0, 1'b0, 10, 4, 3'd0);
      finish_run();
      check_load(1'b0, 10, 4);

      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule